// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine of a 2048-byte serial memory on an open-drain two-wire bus. It samples the clock line (SCL) and the data line (SDA) with a clock-domain synchroniser and detects START and STOP framing. It shifts in a device byte and a word address and acknowledges each accepted byte. The SDA pin is modelled as a pull-low enable (`sda_oe_o`) plus the resolved line value (`sda_i`). Nothing outside this engine drives the line.

The device byte carries a 4-bit type code and three block-select bits, which become the top of the 11-bit memory address. An internal address counter always points one past the last byte accessed. Three read modes use it: current-address read, random read (a dummy write that only loads the counter) and sequential read with wrap inside the 256-byte block. Toward the memory array, the engine presents a combinational byte read port and a one-cycle byte-write handoff. The internal write-cycle busy flag comes in as an input. While it is high, the device byte is refused, which lets the master poll for completion.

Top module: `eep2w_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a fresh device byte, and a STOP (SDA rises while SCL is high) returns the engine to idle with SDA released. After reset the engine is idle, with SDA released and no write strobe.
- R2: A device byte is accepted only when bits 7:4 equal 1010. Any other byte is not acknowledged, and every later byte is ignored until the next START.
- R3: After an accepted device byte, a word address byte or a write data byte, the engine pulls SDA low for the whole ninth SCL clock and releases it at the falling edge that ends that clock.
- R4: In write mode, the word address byte sets the counter to {device byte bits 3:1, word byte}. A repeated START followed by a read-mode device byte then starts a random read, and no data is written.
- R5: Each write data byte produces exactly one single-cycle `wr_valid_o` pulse that carries the counter address and the byte. The low 8 counter bits then advance, with 255 wrapping to 0.
- R6: Read data is sent MSB first. Each bit is changed only after an SCL falling edge, and SDA is released for the master's acknowledge clock.
- R7: A read-mode device byte starts a current-address read. It returns the byte at {device byte bits 3:1, low 8 counter bits}, which is one past the last byte accessed.
- R8: Each master acknowledge in a read makes the engine send the next byte. The low 8 address bits wrap from 255 to 0 and the block bits stay unchanged.
- R9: A missing master acknowledge ends the read. The engine then drives no more data bits until the next START.
- R10: While `busy_i` is high at the end of a device byte, that byte is not acknowledged and the engine stays silent until the next START.
- R11: A START or STOP in the middle of a byte aborts it. A partly received word address leaves the counter's low bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved bus data line value |
| sda_oe_o | output | 1 | When high, the engine pulls SDA low |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_raddr_o | output | 11 | Read port address (current counter value) |
| mem_rdata_i | input | 8 | Read port data, combinational from the address |
| wr_valid_o | output | 1 | One-cycle write handoff strobe |
| wr_addr_o | output | 11 | Write handoff address |
| wr_data_o | output | 8 | Write handoff data |

## Verification
A bus edge takes two synchroniser stages plus the edge register to reach the engine. SDA pull-down changes and the write strobe therefore appear three system cycles after the SCL edge that caused them. The bench holds every SCL phase for eight system cycles and samples SDA only in the middle of the high phase, so the engine's reply has settled and the sample cannot land on a transition. Write handoffs are checked by a monitor at falling clock edges against a queue of expected address and data pairs. Read bytes are compared against a second queue, which the driver fills from its own memory model before each byte is clocked out.

// File: rtl/eep_pkg.sv
package eep_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [3:0] {
      S_IDLE,  // waiting for START
      S_DEV,   // shifting in the device byte
      S_DACK,  // acknowledging the device byte
      S_WADR,  // shifting in the word address
      S_AACK,  // acknowledging the word address
      S_WDAT,  // shifting in write data
      S_WACK,  // acknowledging write data
      S_RDAT,  // shifting out read data
      S_RACK   // listening to the master acknowledge
   } eep_state_t;
endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl,
   output logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl = scl_raw;
         assign sda = sda_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff[0] <= scl_raw;
               sda_ff[0] <= sda_raw;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  scl_ff[i] <= scl_ff[i-1];
                  sda_ff[i] <= sda_ff[i-1];
               end
            end
         end
         assign scl = scl_ff[SYNC_STAGES-1];
         assign sda = sda_ff[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl;
         sda_p <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_p;
   assign scl_fall  = ~scl & scl_p;
   assign start_det = scl & scl_p & sda_p & ~sda;
   assign stop_det  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
   parameter int unsigned BLK_W  = 3,
   parameter int unsigned WORD_W = 8,
   localparam int unsigned ADDR_W = BLK_W + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_blk,
   input  logic [BLK_W-1:0]  blk_in,
   input  logic              load_word,
   input  logic [WORD_W-1:0] word_in,
   input  logic              incr,
   output logic [ADDR_W-1:0] addr
);
   logic [BLK_W-1:0]  blk;
   logic [WORD_W-1:0] word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk  <= '0;
         word <= '0;
      end else begin
         if (set_blk)        blk  <= blk_in;
         if (load_word)      word <= word_in;
         else if (incr)      word <= word + 1'b1;
      end
   end

   assign addr = {blk, word};

   // R8 / R5: the low part wraps inside the block and never carries into it
   a_r8_word_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (incr && !load_word && !set_blk && word == '1) |=> (word == '0 && $stable(blk)));
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
   import eep_pkg::*;
#(
   parameter int unsigned BLK_W       = 3,
   parameter int unsigned TYPE_CODE   = 'hA,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned WORD_W = BYTE_W,
   localparam int unsigned ADDR_W = BLK_W + WORD_W,
   localparam int unsigned TYPE_W = BYTE_W - 1 - BLK_W,
   localparam int unsigned CNT_W  = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] mem_raddr_o,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o
);
   generate
      if (BLK_W < 1 || BLK_W > 3) begin : g_bad_blk
         $error("BLK_W must leave room for a type code (1..3)");
      end
   endgenerate

   logic scl, sda, scl_rise, scl_fall, start_det, stop_det;
   eep_state_t state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic rw, mack, oe;
   logic byte_end, dev_ok;
   logic ctr_set_blk, ctr_load, ctr_inc;
   logic [ADDR_W-1:0] cur_addr;

   eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
      .scl(scl), .sda(sda), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign byte_end = (cnt == CNT_W'(BYTE_W));
   assign dev_ok   = (sh[BYTE_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0]) && !busy_i;

   always_comb begin
      ctr_set_blk = 1'b0;
      ctr_load    = 1'b0;
      ctr_inc     = 1'b0;
      if (!start_det && !stop_det && scl_fall && byte_end) begin
         ctr_set_blk = (state == S_DEV) && dev_ok;
         ctr_load    = (state == S_WADR);
         ctr_inc     = (state == S_WDAT) || (state == S_RDAT);
      end
   end

   eep_addr_ctr #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .set_blk(ctr_set_blk), .blk_in(sh[BLK_W:1]),
      .load_word(ctr_load), .word_in(sh),
      .incr(ctr_inc), .addr(cur_addr)
   );

   assign mem_raddr_o = cur_addr;
   assign sda_oe_o    = oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cnt        <= '0;
         sh         <= '0;
         rw         <= 1'b0;
         mack       <= 1'b0;
         oe         <= 1'b0;
         wr_valid_o <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
      end else begin
         wr_valid_o <= 1'b0;
         if (start_det) begin
            state <= S_DEV;
            cnt   <= '0;
            oe    <= 1'b0;
         end else if (stop_det) begin
            state <= S_IDLE;
            cnt   <= '0;
            oe    <= 1'b0;
         end else begin
            if (scl_rise) begin
               case (state)
                  S_DEV, S_WADR, S_WDAT: begin
                     sh  <= {sh[BYTE_W-2:0], sda};
                     cnt <= cnt + 1'b1;
                  end
                  S_RDAT:  cnt  <= cnt + 1'b1;
                  S_RACK:  mack <= ~sda;
                  default: ;
               endcase
            end
            if (scl_fall) begin
               case (state)
                  S_DEV: if (byte_end) begin
                     cnt <= '0;
                     if (dev_ok) begin
                        state <= S_DACK;
                        oe    <= 1'b1;
                        rw    <= sh[0];
                     end else begin
                        state <= S_IDLE;
                     end
                  end
                  S_DACK: begin
                     if (rw) begin
                        state <= S_RDAT;
                        sh    <= mem_rdata_i;
                        oe    <= ~mem_rdata_i[BYTE_W-1];
                     end else begin
                        state <= S_WADR;
                        oe    <= 1'b0;
                     end
                  end
                  S_WADR: if (byte_end) begin
                     cnt   <= '0;
                     state <= S_AACK;
                     oe    <= 1'b1;
                  end
                  S_AACK: begin
                     state <= S_WDAT;
                     oe    <= 1'b0;
                  end
                  S_WDAT: if (byte_end) begin
                     cnt        <= '0;
                     state      <= S_WACK;
                     oe         <= 1'b1;
                     wr_valid_o <= 1'b1;
                     wr_addr_o  <= cur_addr;
                     wr_data_o  <= sh;
                  end
                  S_WACK: begin
                     state <= S_WDAT;
                     oe    <= 1'b0;
                  end
                  S_RDAT: begin
                     if (byte_end) begin
                        cnt   <= '0;
                        state <= S_RACK;
                        oe    <= 1'b0;
                     end else begin
                        oe <= ~sh[BYTE_W-2];
                        sh <= {sh[BYTE_W-2:0], 1'b0};
                     end
                  end
                  S_RACK: begin
                     if (mack) begin
                        state <= S_RDAT;
                        sh    <= mem_rdata_i;
                        oe    <= ~mem_rdata_i[BYTE_W-1];
                     end else begin
                        state <= S_IDLE;
                        oe    <= 1'b0;
                     end
                  end
                  default: oe <= 1'b0;
               endcase
            end
         end
      end
   end

   // R1 / R11: framing always resynchronises the byte engine
   a_r11_start_resync: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == S_DEV && cnt == '0 && !sda_oe_o));
   a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == S_IDLE && !sda_oe_o));
   // R3: acknowledge is held until the clock that carries it ends
   a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_DACK || state == S_AACK || state == S_WACK) &&
       !scl_fall && !start_det && !stop_det) |=> sda_oe_o);
   // R10: a busy array refuses the device byte
   a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DEV && scl_fall && byte_end && busy_i && !start_det && !stop_det)
      |=> (!sda_oe_o && state == S_IDLE));
   // R5: write handoff is a single-cycle strobe
   a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);
   // R6: read data only moves after a falling SCL edge
   a_r6_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RDAT && scl && !start_det && !stop_det) |=> $stable(sda_oe_o));
endmodule

// File: tb/eep2w_slave_tb.sv
module eep2w_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic busy = 1'b0;
   logic sda_oe;
   logic sda_line;
   logic [10:0] mem_raddr;
   logic [7:0]  mem_rdata;
   logic        wr_valid;
   logic [10:0] wr_addr;
   logic [7:0]  wr_data;
   logic [7:0]  mem [0:2047];
   logic [18:0] wr_q [$];
   logic [7:0]  rd_q [$];
   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign mem_rdata = mem[mem_raddr];

   eep2w_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .busy_i(busy),
      .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
      .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(2);
      scl = 1'b1;   tick(HALF);
      sda_m = 1'b0; tick(HALF);
      scl = 1'b0;   tick(2);
   endtask

   task automatic bus_stop();
      scl = 1'b0; sda_m = 1'b0; tick(HALF);
      scl = 1'b1; tick(HALF);
      sda_m = 1'b1; tick(HALF);
   endtask

   task automatic send_bit(input bit b);
      sda_m = b;  tick(HALF);
      scl = 1'b1; tick(HALF);
      scl = 1'b0; tick(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(HALF);
      scl = 1'b1;   tick(HALF/2);
      ack = ~sda_line;
      tick(HALF/2);
      scl = 1'b0;   tick(2);
   endtask

   task automatic send_ack(input logic [7:0] b, input bit exp_ack, input string req);
      bit a;
      send_byte(b, a);
      check(a == exp_ack, req, a, exp_ack);
   endtask

   // monitor side of the read scoreboard
   task automatic read_byte(input bit mack, input string req);
      logic [7:0] v = '0;
      logic [7:0] e;
      for (int i = 0; i < 8; i++) begin
         sda_m = 1'b1; tick(HALF);
         scl = 1'b1;   tick(HALF/2);
         v = {v[6:0], sda_line};
         tick(HALF/2);
         scl = 1'b0;   tick(2);
      end
      sda_m = ~mack; tick(HALF);
      scl = 1'b1;    tick(HALF/2);
      check(sda_oe == 1'b0, "R6 release in master ack clock", sda_oe, 0);
      tick(HALF/2);
      scl = 1'b0; tick(2);
      sda_m = 1'b1;
      if (rd_q.size() == 0) begin
         check(1'b0, req, v, 0);
      end else begin
         e = rd_q.pop_front();
         check(v == e, req, v, e);
      end
   endtask

   // driver side: expected read byte from the bench memory model
   task automatic expect_rd(input logic [2:0] blk, input logic [7:0] word);
      rd_q.push_back(mem[{blk, word}]);
   endtask

   task automatic random_read(input logic [2:0] blk, input logic [7:0] word,
                              input int n, input string req);
      bus_start();
      send_ack({4'hA, blk, 1'b0}, 1'b1, "R3 dev ack");
      send_ack(word, 1'b1, "R3 addr ack");
      bus_start();
      send_ack({4'hA, blk, 1'b1}, 1'b1, "R4 read dev ack");
      for (int k = 0; k < n; k++) begin
         expect_rd(blk, 8'(word + k));
         read_byte(k != n - 1, req);
      end
      bus_stop();
   endtask

   // write scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (wr_q.size() == 0) begin
            check(1'b0, "R4 R5 unexpected write", {wr_addr, wr_data}, 0);
         end else begin
            logic [18:0] e;
            e = wr_q.pop_front();
            check({wr_addr, wr_data} == e, "R5 write handoff", {wr_addr, wr_data}, e);
         end
         mem[wr_addr] <= wr_data;
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      tick(150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 37 + 5);
      tick(4);
      rst_n = 1'b1;
      tick(4);
      // R1: reset state
      check(sda_oe == 1'b0, "R1 reset sda released", sda_oe, 0);
      check(wr_valid == 1'b0, "R1 reset no write strobe", wr_valid, 0);

      // R2: wrong type code refused, following byte ignored
      bus_start();
      send_ack(8'hB6, 1'b0, "R2 wrong type nack");
      send_ack(8'h55, 1'b0, "R2 later byte ignored");
      bus_stop();

      // R5: single byte write
      wr_q.push_back({11'h320, 8'hA5});
      bus_start();
      send_ack(8'hA6, 1'b1, "R3 dev ack");
      send_ack(8'h20, 1'b1, "R3 addr ack");
      send_ack(8'hA5, 1'b1, "R3 data ack");
      bus_stop();

      // R5: write crossing the top of the block wraps to word 0
      wr_q.push_back({11'h2FF, 8'h11});
      wr_q.push_back({11'h200, 8'h22});
      bus_start();
      send_ack(8'hA4, 1'b1, "R3 dev ack");
      send_ack(8'hFF, 1'b1, "R3 addr ack");
      send_ack(8'h11, 1'b1, "R5 data ack");
      send_ack(8'h22, 1'b1, "R5 data ack wrap");
      bus_stop();
      check(wr_q.size() == 0, "R5 all writes handed off", wr_q.size(), 0);

      // R7: current-address read continues from word 0x01 of block 2
      bus_start();
      send_ack(8'hA5, 1'b1, "R7 read dev ack");
      expect_rd(3'd2, 8'h01);
      read_byte(1'b0, "R7 current address read");
      bus_stop();

      // R4 / R8: random then sequential read
      random_read(3'd5, 8'h10, 3, "R8 sequential read");
      // R8: sequential read wraps inside block 1
      random_read(3'd1, 8'hFE, 3, "R8 wrap 255 to 0");
      // R7: counter is one past the last byte read (0x101)
      bus_start();
      send_ack(8'hA3, 1'b1, "R7 read dev ack");
      expect_rd(3'd1, 8'h01);
      read_byte(1'b0, "R7 after sequential read");
      // R9: no more data after master nack, even with more clocks
      for (int i = 0; i < 9; i++) begin
         sda_m = 1'b1; tick(HALF);
         scl = 1'b1;   tick(HALF/2);
         check(sda_line == 1'b1, "R9 silent after nack", sda_line, 1);
         tick(HALF/2);
         scl = 1'b0;   tick(2);
      end
      bus_stop();

      // set counter to 0x482
      random_read(3'd4, 8'h80, 2, "R4 random read");

      // R10: busy refuses the device byte
      busy = 1'b1;
      bus_start();
      send_ack(8'hA0, 1'b0, "R10 busy nack");
      send_ack(8'h00, 1'b0, "R10 silent while refused");
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_ack(8'hA0, 1'b1, "R10 ack when not busy");
      bus_stop();

      // R11: STOP in the middle of a word address leaves the low bits
      bus_start();
      send_ack(8'hA6, 1'b1, "R3 dev ack");
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_stop();
      bus_start();
      send_ack(8'hA7, 1'b1, "R11 read dev ack");
      expect_rd(3'd3, 8'h82);
      read_byte(1'b0, "R11 counter kept after aborted address");
      bus_stop();

      // R11: START in the middle of a device byte resynchronises
      bus_start();
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      bus_start();
      send_ack(8'hA7, 1'b1, "R11 dev ack after restart");
      expect_rd(3'd3, 8'h83);
      read_byte(1'b0, "R11 read after restart");
      bus_stop();

      check(rd_q.size() == 0, "R8 read queue drained", rd_q.size(), 0);
      check(wr_q.size() == 0, "R4 no data written by reads", wr_q.size(), 0);
      tick(20);
      finish_run();
   end
endmodule